// File: doc/BRIEF.md
# Add-On FIFO Access Port with DMA Request Flags

This block is the add-on side of a pair of data FIFOs that sit between a host bus and add-on logic. One FIFO carries data toward the host (add-on writes, host pops), the other carries data from the host (host pushes, add-on reads). Both FIFOs, eight 32-bit entries each, are stored inside the block. The host side is a plain push/pop port.

Add-on logic reaches the FIFOs in two ways. It can make an ordinary register access: chip select plus a word address that decodes to the FIFO location, qualified by a read or write strobe. It can also use dedicated direct read and write strobes that need neither select nor address, which suits a DMA engine. A mode input chooses a 32-bit or a 16-bit data path. In 16-bit mode, two half-word writes are packed into one entry and each entry is read back as two half-words. The full flag of the outbound FIFO and the empty flag of the inbound FIFO are registered. When low, each one serves as a DMA request.

Top module: `addon_fifo_port`

## Requirements
- R1: A decoded access happens when `sel_n` is low and `addr` (word address bits 6..2) equals 5'b01000. `wr_n` low then writes and `rd_n` low then reads. With any other `addr`, or with `sel_n` high, the FIFOs are untouched.
- R2: While `dwr_n` is low, each clock edge performs one write into the outbound FIFO, with no select or address decode.
- R3: While `drd_n` is low, each clock edge performs one read from the inbound FIFO, with no select or address decode. `dout` always shows the current read data without a clock delay.
- R4: With `wide_mode`=1, each write pushes `din[31:0]` as one entry. With `wide_mode`=0, the first write holds `din[15:0]` as the low half and pushes nothing. The second write pushes {second `din[15:0]`, first `din[15:0]`}.
- R5: With `wide_mode`=0, `dout[15:0]` first shows bits 15..0 of the head entry and `dout[31:16]` reads zero. A read then switches to bits 31..16. The next read pops the entry.
- R6: `wr_full` is high exactly when the outbound FIFO holds 8 entries. Its low level is the DMA write request.
- R7: `rd_empty` is high exactly when the inbound FIFO holds no entry. Its low level is the DMA read request.
- R8: A write while `wr_full` is high is dropped, and it sets `access_err`. Only reset clears `access_err`.
- R9: A read while `rd_empty` is high pops nothing, and it sets `access_err`.
- R10: While either direct strobe is low, any decoded access in the same cycle is ignored.
- R11: The flags change only on the clock edge that performs the push or pop that changes them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wide_mode | input | 1 | 1: 32-bit path, 0: 16-bit path |
| sel_n | input | 1 | Active-low chip select for decoded access |
| addr | input | 5 | Word address bits 6..2 |
| wr_n | input | 1 | Active-low write for decoded access |
| rd_n | input | 1 | Active-low read for decoded access |
| dwr_n | input | 1 | Active-low direct write strobe |
| drd_n | input | 1 | Active-low direct read strobe |
| din | input | 32 | Add-on write data |
| dout | output | 32 | Add-on read data (head of inbound FIFO) |
| wr_full | output | 1 | Outbound FIFO full; low = DMA write request |
| rd_empty | output | 1 | Inbound FIFO empty; low = DMA read request |
| access_err | output | 1 | Sticky overflow/underflow error |
| h_push | input | 1 | Host push into inbound FIFO |
| h_wdata | input | 32 | Host push data |
| h_h2a_full | output | 1 | Inbound FIFO full |
| h_pop | input | 1 | Host pop from outbound FIFO |
| h_rdata | output | 32 | Head of outbound FIFO |
| h_a2h_empty | output | 1 | Outbound FIFO empty |

## Verification
Each push or pop takes effect on the single clock edge during which its strobe is held. `wr_full`, `rd_empty`, `access_err` and the host-side flags are therefore due one edge after the stimulus. `dout` and `h_rdata` follow the FIFO head combinationally, so they are also valid right after that edge. The bench changes inputs on the falling edge, holds them across exactly one rising edge, and samples on the next falling edge. Every result is thus read half a cycle after the edge that made it.

// File: rtl/addon_fifo_pkg.sv
// Shared constants for the add-on FIFO port.
// Assumes the FIFO location decode value is fixed by the add-on register map.
package addon_fifo_pkg;
    localparam int unsigned DATA_W   = 32;
    localparam int unsigned HALF_W   = DATA_W / 2;
    localparam int unsigned ADDR_W   = 5;
    localparam logic [ADDR_W-1:0] FIFO_LOC = 5'b01000;
    typedef logic [DATA_W-1:0] word_t;
endpackage

// File: rtl/addon_sync_fifo.sv
// Synchronous FIFO with registered full/empty flags.
// Pushes when full and pops when empty are ignored; the caller flags errors.
// Assumes DEPTH is a power of two.
module addon_sync_fifo #(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             full,
    output logic             empty
);
    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned CW = AW + 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr, rptr;
    logic [CW-1:0]    count, count_nxt;
    logic             do_push, do_pop;

    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rptr];

    // Next occupancy from accepted push and pop.
    always_comb begin
        count_nxt = count;
        if (do_push && !do_pop) count_nxt = count + CW'(1);
        if (do_pop && !do_push) count_nxt = count - CW'(1);
    end

    // Pointers, occupancy and registered flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
            full  <= 1'b0;
            empty <= 1'b1;
        end else begin
            if (do_push) wptr <= wptr + AW'(1);
            if (do_pop)  rptr <= rptr + AW'(1);
            count <= count_nxt;
            full  <= (count_nxt == CW'(DEPTH));
            empty <= (count_nxt == '0);
        end
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= wdata;
    end
endmodule

// File: rtl/addon_wr_packer.sv
// Turns add-on writes into FIFO pushes; in narrow mode joins two half-words,
// low half first. Assumes the width mode does not change mid-pair.
module addon_wr_packer
    import addon_fifo_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wide,
    input  logic  req,
    input  logic  room,
    input  word_t din,
    output logic  push,
    output word_t pdata
);
    logic              have_lo;
    logic [HALF_W-1:0] lo_q;
    logic              take;

    assign take = req && room;

    // Push selection and packed data.
    always_comb begin
        if (wide) begin
            push  = take;
            pdata = din;
        end else begin
            push  = take && have_lo;
            pdata = {din[HALF_W-1:0], lo_q};
        end
    end

    // Half-word staging register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_lo <= 1'b0;
            lo_q    <= '0;
        end else if (take && !wide) begin
            if (!have_lo) lo_q <= din[HALF_W-1:0];
            have_lo <= !have_lo;
        end
    end
endmodule

// File: rtl/addon_rd_unpacker.sv
// Presents FIFO head to the add-on; in narrow mode hands out low half,
// then high half, popping after the high half. Assumes static width mode.
module addon_rd_unpacker
    import addon_fifo_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wide,
    input  logic  req,
    input  logic  avail,
    input  word_t head,
    output logic  pop,
    output word_t dout
);
    logic hi_sel;
    logic take;

    assign take = req && avail;

    // Pop and output lane selection.
    always_comb begin
        if (wide) begin
            pop  = take;
            dout = head;
        end else begin
            pop  = take && hi_sel;
            dout = {{HALF_W{1'b0}},
                    hi_sel ? head[DATA_W-1:HALF_W] : head[HALF_W-1:0]};
        end
    end

    // Half select toggles on each narrow read.
    always_ff @(posedge clk) begin
        if (!rst_n)             hi_sel <= 1'b0;
        else if (take && !wide) hi_sel <= !hi_sel;
    end
endmodule

// File: rtl/addon_fifo_port.sv
// Add-on access port to an outbound and an inbound FIFO.
// Decoded or direct-strobe access; direct strobes win. Flags registered.
// Assumes wide_mode is stable while a half-word pair is in progress.
module addon_fifo_port
    import addon_fifo_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide_mode,
    input  logic              sel_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic              dwr_n,
    input  logic              drd_n,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              wr_full,
    output logic              rd_empty,
    output logic              access_err,
    input  logic              h_push,
    input  logic [DATA_W-1:0] h_wdata,
    output logic              h_h2a_full,
    input  logic              h_pop,
    output logic [DATA_W-1:0] h_rdata,
    output logic              h_a2h_empty
);
    logic  dec_hit, direct_any, wr_req, rd_req;
    logic  a2h_push, h2a_pop;
    word_t a2h_wdata, h2a_head;

    // Access decode with direct-strobe priority.
    always_comb begin
        dec_hit    = !sel_n && (addr == FIFO_LOC);
        direct_any = !dwr_n || !drd_n;
        wr_req     = !dwr_n || (!direct_any && dec_hit && !wr_n);
        rd_req     = !drd_n || (!direct_any && dec_hit && !rd_n);
    end

    // Sticky overflow/underflow error.
    always_ff @(posedge clk) begin
        if (!rst_n) access_err <= 1'b0;
        else if ((wr_req && wr_full) || (rd_req && rd_empty)) access_err <= 1'b1;
    end

    addon_wr_packer u_pack (
        .clk   (clk),
        .rst_n (rst_n),
        .wide  (wide_mode),
        .req   (wr_req),
        .room  (!wr_full),
        .din   (din),
        .push  (a2h_push),
        .pdata (a2h_wdata)
    );

    addon_sync_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_a2h (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (a2h_push),
        .wdata (a2h_wdata),
        .pop   (h_pop),
        .head  (h_rdata),
        .full  (wr_full),
        .empty (h_a2h_empty)
    );

    addon_sync_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_h2a (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (h_push),
        .wdata (h_wdata),
        .pop   (h2a_pop),
        .head  (h2a_head),
        .full  (h_h2a_full),
        .empty (rd_empty)
    );

    addon_rd_unpacker u_unpack (
        .clk   (clk),
        .rst_n (rst_n),
        .wide  (wide_mode),
        .req   (rd_req),
        .avail (!rd_empty),
        .head  (h2a_head),
        .pop   (h2a_pop),
        .dout  (dout)
    );
endmodule

// File: rtl/addon_fifo_port_chk.sv
// Port-level properties of addon_fifo_port, attached by bind.
module addon_fifo_port_chk (
    input logic clk,
    input logic rst_n,
    input logic wide_mode,
    input logic dwr_n,
    input logic wr_full,
    input logic rd_empty,
    input logic access_err,
    input logic h_push,
    input logic h_pop,
    input logic h_a2h_empty
);
    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        access_err |=> access_err);

    assert_full_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_full && !h_pop) |=> wr_full);

    assert_empty_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_empty && !h_push) |=> rd_empty);

    assert_fill_needs_push_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_empty) |-> $past(h_push));

    assert_direct_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!dwr_n && wide_mode && !wr_full) |=> !h_a2h_empty);
endmodule

bind addon_fifo_port addon_fifo_port_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wide_mode   (wide_mode),
    .dwr_n       (dwr_n),
    .wr_full     (wr_full),
    .rd_empty    (rd_empty),
    .access_err  (access_err),
    .h_push      (h_push),
    .h_pop       (h_pop),
    .h_a2h_empty (h_a2h_empty)
);

// File: tb/addon_fifo_port_test.sv
// Directed bench: one task per scenario; inputs change on falling edges.
module addon_fifo_port_test;
    logic        clk = 1'b0;
    logic        rst_n, wide_mode, sel_n, wr_n, rd_n, dwr_n, drd_n;
    logic [4:0]  addr;
    logic [31:0] din, dout, h_wdata, h_rdata;
    logic        wr_full, rd_empty, access_err, h_push, h_h2a_full, h_pop, h_a2h_empty;
    int          total = 0, bad = 0;

    always #10 clk = ~clk;   // 50 MHz

    addon_fifo_port uut (
        .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .sel_n(sel_n),
        .addr(addr), .wr_n(wr_n), .rd_n(rd_n), .dwr_n(dwr_n), .drd_n(drd_n),
        .din(din), .dout(dout), .wr_full(wr_full), .rd_empty(rd_empty),
        .access_err(access_err), .h_push(h_push), .h_wdata(h_wdata),
        .h_h2a_full(h_h2a_full), .h_pop(h_pop), .h_rdata(h_rdata),
        .h_a2h_empty(h_a2h_empty)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        sel_n = 1; wr_n = 1; rd_n = 1; dwr_n = 1; drd_n = 1;
        addr = 5'b0; din = '0; h_push = 0; h_pop = 0; h_wdata = '0;
    endtask

    task automatic do_reset(input logic wide);
        @(negedge clk);
        idle(); wide_mode = wide; rst_n = 0;
        @(negedge clk); @(negedge clk);
        rst_n = 1;
    endtask

    // One-cycle pulses; results sampled on the following falling edge.
    task automatic dec_write(input logic [4:0] a, input logic [31:0] d);
        sel_n = 0; addr = a; wr_n = 0; din = d;
        @(negedge clk); idle();
    endtask
    task automatic dir_write(input logic [31:0] d);
        dwr_n = 0; din = d;
        @(negedge clk); idle();
    endtask
    task automatic dir_read();
        drd_n = 0;
        @(negedge clk); idle();
    endtask
    task automatic host_push(input logic [31:0] d);
        h_push = 1; h_wdata = d;
        @(negedge clk); idle();
    endtask
    task automatic host_pop();
        h_pop = 1;
        @(negedge clk); idle();
    endtask

    task automatic t_reset();
        do_reset(1);
        check("R6 reset wr_full", 32'(wr_full), 0);
        check("R7 reset rd_empty", 32'(rd_empty), 1);
        check("R8 reset err", 32'(access_err), 0);
    endtask

    task automatic t_decode();
        do_reset(1);
        dec_write(5'b01001, 32'hDEAD0001);
        check("R1 wrong addr ignored", 32'(h_a2h_empty), 1);
        dec_write(5'b01000, 32'hCAFE0002);
        check("R1 decoded write", h_rdata, 32'hCAFE0002);
        check("R11 empty falls after push", 32'(h_a2h_empty), 0);
        host_push(32'h12345678);
        sel_n = 0; addr = 5'b01000; rd_n = 0;
        @(negedge clk); idle();
        check("R1 decoded read pops", 32'(rd_empty), 1);
    endtask

    task automatic t_direct();
        do_reset(1);
        dir_write(32'hA5A5_0003);
        check("R2 direct write", h_rdata, 32'hA5A5_0003);
        host_push(32'h0BADF00D);
        check("R7 rd_empty low with data", 32'(rd_empty), 0);
        check("R3 dout shows head", dout, 32'h0BADF00D);
        dir_read();
        check("R3 direct read empties", 32'(rd_empty), 1);
    endtask

    task automatic t_narrow();
        do_reset(0);
        dir_write(32'hFFFF_AAAA);
        check("R4 first half no push", 32'(h_a2h_empty), 1);
        dec_write(5'b01000, 32'hEEEE_BBBB);
        check("R4 packed entry", h_rdata, 32'hBBBB_AAAA);
        host_push(32'h2222_3333);
        check("R5 low half first", dout, 32'h0000_3333);
        dir_read();
        check("R5 high half second", dout, 32'h0000_2222);
        check("R5 entry kept", 32'(rd_empty), 0);
        dir_read();
        check("R5 pop after high half", 32'(rd_empty), 1);
        check("R5 no error", 32'(access_err), 0);
    endtask

    task automatic t_full();
        do_reset(1);
        for (int i = 0; i < 7; i++) dir_write(32'h100 + 32'(i));
        check("R6 not full at 7", 32'(wr_full), 0);
        dir_write(32'h107);
        check("R6 full at 8", 32'(wr_full), 1);
        dir_write(32'hBAD);
        check("R8 overflow err", 32'(access_err), 1);
        for (int i = 0; i < 8; i++) begin
            check("R8 data intact", h_rdata, 32'h100 + 32'(i));
            host_pop();
        end
        check("R8 dropped write absent", 32'(h_a2h_empty), 1);
        check("R8 err sticky", 32'(access_err), 1);
    endtask

    task automatic t_underflow();
        do_reset(1);
        dir_read();
        check("R9 underflow err", 32'(access_err), 1);
        host_push(32'h77);
        check("R9 later data intact", dout, 32'h77);
    endtask

    task automatic t_priority();
        do_reset(1);
        host_push(32'h5555);
        dwr_n = 0; din = 32'h6666;
        sel_n = 0; addr = 5'b01000; rd_n = 0;
        @(negedge clk); idle();
        check("R10 direct write done", h_rdata, 32'h6666);
        check("R10 decoded read ignored", dout, 32'h5555);
        check("R10 inbound kept", 32'(rd_empty), 0);
    endtask

    initial begin
        idle(); wide_mode = 1; rst_n = 0;
        t_reset();
        t_decode();
        t_direct();
        t_narrow();
        t_full();
        t_underflow();
        t_priority();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule